// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side each run on their own free-running clock. The two clocks may be one net or entirely unrelated, and a write and a read may happen on the same edge. A word is accepted when a pair of write enables is active, and a word is delivered when a pair of read enables is active. Read data sits in an output register, and an output enable drives that register onto the read-data pins or leaves the pins floating.

Pointers cross between the two domains as gray code through two-flop synchronisers. Full is computed from the write side's view and Empty from the read side's view, so each flag clears a few cycles late and never early. Two further flags report when the buffer is nearly empty or nearly full. Their thresholds are offsets loaded through the data bus: if the load/enable input is held low through the end of reset, the following write-clock edges store the bus into the two offset registers in turn.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_en_n` low, `wr_en_ld` high and `full` low, `din` is stored. While both enables stay active, one word is stored on every edge with no idle cycle, so DEPTH (16) edges fill an empty buffer.
- R2: On a rising `rd_clk` edge with `rd_en_a_n` and `rd_en_b_n` both low and `empty` low, the oldest word is moved into the output register and appears on `dout` after that edge. Words leave in the order they were stored.
- R3: A write attempt while `full` is high is ignored. No word is stored, and the buffer contents and pointer are unchanged.
- R4: A read attempt while `empty` is high is ignored. The read pointer does not move and `dout` keeps the last word read.
- R5: No transfer happens when either enable of a port is inactive. On the write side this is `wr_en_n` high, or `wr_en_ld` low outside load mode. On the read side this is either read enable high.
- R6: With `oe_n` high, every bit of `dout` is high impedance. With `oe_n` low, `dout` drives the output register.
- R7: Holding `rst_n` low for at least two edges of each clock clears both pointers. It sets `empty` and `almost_empty` to 1, sets `full` and `almost_full` to 0, sets the output register to 0, and resets both offsets to 7.
- R8: After the first write into an empty buffer, `empty` falls within 4 read-clock cycles. After a read from a full buffer, `full` falls within 5 write-clock cycles.
- R9: `almost_empty` is 1 when the fill count seen by the read side is at or below the almost-empty offset. With the default offset it is 1 at 7 words and 0 at 8.
- R10: `almost_full` is 1 when DEPTH minus the fill count seen by the write side is at or below the almost-full offset. With the default offset and DEPTH 16 it is 0 at 8 words and 1 at 9.
- R11: If `wr_en_ld` is low on the last write edge of reset, the block enters load mode. Each `wr_clk` edge with `wr_en_n` low and `wr_en_ld` low then writes `din[4:0]` to the almost-empty offset, then to the almost-full offset, and then back to the almost-empty offset, alternating. No word enters the buffer during loading. The first edge with `wr_en_ld` high leaves load mode.
- R12: With unrelated clocks and reads and writes enabled at the same time, a long stream passes through with no word lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by each clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en_ld | input | 1 | Second write enable, active high; low through reset selects offset loading |
| din | input | 9 | Write data, also the offset value in load mode |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Read data from the output register, high impedance when `oe_n` is high |
| empty | output | 1 | Buffer holds no word (read domain) |
| full | output | 1 | Buffer holds DEPTH words (write domain) |
| almost_empty | output | 1 | Fill count at or below the almost-empty offset |
| almost_full | output | 1 | Free space at or below the almost-full offset |

## Verification
A read result is due on `dout` at the read edge that takes the word. The scoreboard monitor notes the pre-edge enables and `empty` on that edge and compares at the following falling edge. A write counts as accepted only if `full` was low at the falling edge before the write edge, and the driver pushes the expected word at that edge. Flag changes need up to three edges of the other clock: one pointer register, two synchroniser flops and the flag register. Every flag check therefore waits at least eight read cycles after the last transfer, and the two latency checks count falling edges against the bounds in R8.

// File: rtl/dcff_pkg.sv
// Shared constants and types for the dual-clock flag FIFO.
// Assumes: the data bus is a fixed 9 bits; the offset reset value fits in the pointer width.
package dcff_pkg;
    localparam int DATA_W     = 9;
    localparam int DEF_OFFSET = 7;

    // Which offset register the next load-mode write targets.
    typedef enum logic {
        SLOT_AE = 1'b0,
        SLOT_AF = 1'b1
    } slot_e;
endpackage

// File: rtl/dcff_gray_sync.sv
// Two-flop synchroniser for a gray-coded pointer, with gray-to-binary decode.
// Assumes: the input changes by at most one bit per source-clock edge (gray code).
module dcff_gray_sync #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    // Two-stage capture of the foreign-domain pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the XOR of itself and all higher bits.
    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign bin_out[i] = ^sync_q[PW-1:i];
    end
endmodule

// File: rtl/dcff_wr_side.sv
// Write-domain control: write pointer, Full and Almost Full flags, offset loading.
// Assumes: DEPTH is a power of two; PW = log2(DEPTH)+1; rst_n held for >= 2 write edges.
module dcff_wr_side
    import dcff_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              wr_en_ld,
    input  logic [DATA_W-1:0] din,
    input  logic [PW-1:0]     rgray_in,
    output logic [PW-1:0]     wgray,
    output logic [AW-1:0]     waddr,
    output logic              wr_store,
    output logic              full,
    output logic              almost_full,
    output logic [PW-1:0]     ae_off
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] DEF_P   = PW'(DEF_OFFSET);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] fill_nx;
    logic [PW-1:0] af_off;
    logic          load_mode;
    logic          wr_fire;
    logic          full_nx;
    logic          afull_nx;
    slot_e         slot;

    dcff_gray_sync #(.PW(PW)) u_rptr_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .gray_in (rgray_in),
        .bin_out (rbin_s)
    );

    // Write request and the next pointer / flag values.
    always_comb begin
        wr_fire  = !wr_en_n && wr_en_ld;
        wr_store = wr_fire && !full;
        wbin_nx  = wbin + PW'(wr_store);
        fill_nx  = wbin_nx - rbin_s;
        full_nx  = (fill_nx == DEPTH_P);
        afull_nx = ((DEPTH_P - fill_nx) <= af_off);
    end

    assign waddr = wbin[AW-1:0];

    // Pointer and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin        <= '0;
            wgray       <= '0;
            full        <= 1'b0;
            almost_full <= 1'b0;
        end else begin
            wbin        <= wbin_nx;
            wgray       <= wbin_nx ^ (wbin_nx >> 1);
            full        <= full_nx;
            almost_full <= afull_nx;
        end
    end

    // Load-mode entry at reset and alternating offset writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_mode <= !wr_en_ld;
            slot      <= SLOT_AE;
            ae_off    <= DEF_P;
            af_off    <= DEF_P;
        end else if (wr_en_ld) begin
            load_mode <= 1'b0;
        end else if (load_mode && !wr_en_n) begin
            if (slot == SLOT_AE) ae_off <= din[PW-1:0];
            else                 af_off <= din[PW-1:0];
            slot <= (slot == SLOT_AE) ? SLOT_AF : SLOT_AE;
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && full) |=> $stable(wbin));

    a_r10_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ((wbin - rbin_s) <= DEPTH_P));

    a_r11_load_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (load_mode && !wr_en_ld && !wr_en_n) |=> (slot != $past(slot)));

    a_r7_reset_not_full: assert property (@(posedge clk)
        !rst_n |=> (!full && !almost_full));
endmodule

// File: rtl/dcff_rd_side.sv
// Read-domain control: read pointer, output register, Empty and Almost Empty flags.
// Assumes: the almost-empty offset is static while data flows (it is loaded in the write domain).
module dcff_rd_side
    import dcff_pkg::*;
#(
    parameter int AW = 4,
    parameter int PW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic [PW-1:0]     wgray_in,
    input  logic [PW-1:0]     ae_off,
    input  logic [DATA_W-1:0] mem_word,
    output logic [PW-1:0]     rgray,
    output logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] q,
    output logic              empty,
    output logic              almost_empty
);
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] fill_nx;
    logic          rd_req;
    logic          rd_take;

    dcff_gray_sync #(.PW(PW)) u_wptr_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .gray_in (wgray_in),
        .bin_out (wbin_s)
    );

    // Read request and next pointer / flag values.
    always_comb begin
        rd_req  = !rd_en_a_n && !rd_en_b_n;
        rd_take = rd_req && !empty;
        rbin_nx = rbin + PW'(rd_take);
        fill_nx = wbin_s - rbin_nx;
    end

    assign raddr = rbin[AW-1:0];

    // Pointer, flag and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin         <= '0;
            rgray        <= '0;
            q            <= '0;
            empty        <= 1'b1;
            almost_empty <= 1'b1;
        end else begin
            rbin         <= rbin_nx;
            rgray        <= rbin_nx ^ (rbin_nx >> 1);
            empty        <= (fill_nx == '0);
            almost_empty <= (fill_nx <= ae_off);
            if (rd_take) q <= mem_word;
        end
    end

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> ($stable(rbin) && $stable(q)));

    a_r9_empty_implies_ae: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty);

    a_r7_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (empty && almost_empty));
endmodule

// File: rtl/dual_clock_flag_fifo.sv
// Top: dual-clock 9-bit FIFO with storage array, two control domains and three-state output.
// Assumes: DEPTH is a power of two and at most 16 so offsets fit in din[4:0] at defaults.
module dual_clock_flag_fifo
    import dcff_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              wr_en_ld,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     ae_off;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic              wr_store;
    logic [DATA_W-1:0] q;

    dcff_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk         (wr_clk),
        .rst_n       (rst_n),
        .wr_en_n     (wr_en_n),
        .wr_en_ld    (wr_en_ld),
        .din         (din),
        .rgray_in    (rgray),
        .wgray       (wgray),
        .waddr       (waddr),
        .wr_store    (wr_store),
        .full        (full),
        .almost_full (almost_full),
        .ae_off      (ae_off)
    );

    dcff_rd_side #(.AW(AW), .PW(PW)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rst_n),
        .rd_en_a_n    (rd_en_a_n),
        .rd_en_b_n    (rd_en_b_n),
        .wgray_in     (wgray),
        .ae_off       (ae_off),
        .mem_word     (mem[raddr]),
        .rgray        (rgray),
        .raddr        (raddr),
        .q            (q),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    // Storage array write port, write domain.
    always_ff @(posedge wr_clk) begin
        if (wr_store) mem[waddr] <= din;
    end

    // Three-state read-data pins.
    assign dout = oe_n ? {DATA_W{1'bz}} : q;
endmodule

// File: tb/dual_clock_flag_fifo_tb_top.sv
module dual_clock_flag_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = CLK_PERIOD * 8 / 5;
    localparam int DEPTH      = 16;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_n = 1'b1;
    logic       wr_en_ld = 1'b1;
    logic [8:0] din = '0;
    logic       rd_en_a_n = 1'b1;
    logic       rd_en_b_n = 1'b1;
    logic       oe_n = 1'b0;
    logic [8:0] dout;
    logic       empty, full, almost_empty, almost_full;

    int         checks = 0;
    int         errors = 0;
    int         popped = 0;
    logic [8:0] last_word = '0;
    logic [8:0] exp_q [$];

    dual_clock_flag_fifo #(.DEPTH(DEPTH)) dut_i (
        .wr_clk       (wr_clk),
        .rd_clk       (rd_clk),
        .rst_n        (rst_n),
        .wr_en_n      (wr_en_n),
        .wr_en_ld     (wr_en_ld),
        .din          (din),
        .rd_en_a_n    (rd_en_a_n),
        .rd_en_b_n    (rd_en_b_n),
        .oe_n         (oe_n),
        .dout         (dout),
        .empty        (empty),
        .full         (full),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

    initial forever #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    initial forever #(RD_PERIOD / 2) rd_clk = ~rd_clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: a read edge with both enables low and empty low yields the next expected word (R2).
    always @(posedge rd_clk) begin
        if (rst_n && !rd_en_a_n && !rd_en_b_n && !empty) begin
            @(negedge rd_clk);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected word", int'(dout), 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(dout === e, "R2 read order", int'(dout), int'(e));
                last_word = e;
                popped++;
            end
        end
    end

    task automatic do_reset(input logic ld);
        @(negedge wr_clk);
        rst_n = 1'b0; wr_en_ld = ld; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        last_word = '0;
    endtask

    // Driver: write one word; pushes to the scoreboard only if accepted (R1, R3).
    task automatic push_word(input logic [8:0] d, output bit acc);
        @(negedge wr_clk);
        din = d; wr_en_n = 1'b0;
        acc = !full && wr_en_ld;
        @(posedge wr_clk);
        if (acc) exp_q.push_back(d);
    endtask

    task automatic push_n(input int n, input logic [8:0] base);
        for (int i = 0; i < n; i++) begin
            bit a;
            push_word(base + 9'(i), a);
        end
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic load_word(input logic [8:0] d);
        @(negedge wr_clk);
        din = d; wr_en_n = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic drain();
        @(negedge rd_clk);
        rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        while (exp_q.size() != 0) @(negedge rd_clk);
        settle();
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        settle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int cnt;
        int base_pop;
        bit acc;

        // R7: reset state.
        do_reset(1'b1);
        @(negedge rd_clk);
        chk(empty === 1'b1, "R7 empty", empty, 1);
        chk(almost_empty === 1'b1, "R7 almost_empty", almost_empty, 1);
        chk(full === 1'b0, "R7 full", full, 0);
        chk(almost_full === 1'b0, "R7 almost_full", almost_full, 0);
        chk(dout === 9'h000, "R7 output register", int'(dout), 0);

        // R6: three-state output.
        oe_n = 1'b1; #1;
        chk(dout === {9{1'bz}}, "R6 high impedance", int'(dout), 0);
        oe_n = 1'b0; #1;
        chk(dout === 9'h000, "R6 driven", int'(dout), 0);

        // R5: writes blocked by either inactive write enable.
        @(negedge wr_clk); wr_en_n = 1'b0; wr_en_ld = 1'b0; din = 9'h155;
        repeat (4) @(negedge wr_clk);
        wr_en_n = 1'b1; wr_en_ld = 1'b1;
        repeat (4) @(negedge wr_clk);
        settle();
        chk(empty === 1'b1, "R5 write enables gated", empty, 1);

        // R8: empty falls within 4 read cycles of the first write.
        push_word(9'h010, acc);
        @(negedge wr_clk); wr_en_n = 1'b1;
        cnt = 0;
        while (empty && cnt < 20) begin @(negedge rd_clk); cnt++; end
        chk(cnt <= 4, "R8 empty latency", cnt, 4);

        // R9: almost_empty boundary at 7 / 8 words with default offset.
        push_n(6, 9'h011);
        settle();
        chk(almost_empty === 1'b1, "R9 seven words", almost_empty, 1);
        push_n(1, 9'h017);
        settle();
        chk(almost_empty === 1'b0, "R9 eight words", almost_empty, 0);

        // R10: almost_full boundary at 8 / 9 words.
        chk(almost_full === 1'b0, "R10 eight words", almost_full, 0);
        push_n(1, 9'h018);
        settle();
        chk(almost_full === 1'b1, "R10 nine words", almost_full, 1);

        // R1: remaining words back-to-back fill the buffer.
        push_n(7, 9'h019);
        settle();
        chk(full === 1'b1, "R1 full after DEPTH writes", full, 1);
        chk(exp_q.size() == DEPTH, "R1 accepted count", exp_q.size(), DEPTH);

        // R3: write while full is ignored.
        push_word(9'h1AA, acc);
        @(negedge wr_clk); wr_en_n = 1'b1;
        chk(acc == 1'b0, "R3 write refused", int'(acc), 0);

        // R8: full falls within 5 write cycles after one read.
        @(negedge rd_clk); rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        @(negedge rd_clk); rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        cnt = 0;
        while (full && cnt < 20) begin @(negedge wr_clk); cnt++; end
        chk(cnt <= 5, "R8 full latency", cnt, 5);

        // R3: drain; the refused word must not appear (monitor flags extras).
        base_pop = popped;
        drain();
        chk(popped - base_pop == DEPTH - 1, "R3 drained count", popped - base_pop, DEPTH - 1);
        chk(empty === 1'b1, "R3 empty after drain", empty, 1);

        // R4: read while empty is ignored; dout holds last word.
        @(negedge rd_clk); rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        repeat (6) @(negedge rd_clk);
        chk(dout === 9'h01F, "R4 dout held", int'(dout), 9'h01F);
        chk(empty === 1'b1, "R4 still empty", empty, 1);
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;

        // R5: one read enable inactive blocks the read.
        push_n(1, 9'h0C3);
        settle();
        @(negedge rd_clk); rd_en_a_n = 1'b0; rd_en_b_n = 1'b1;
        repeat (6) @(negedge rd_clk);
        chk(empty === 1'b0, "R5 read gated", empty, 0);
        chk(dout === 9'h01F, "R5 dout unchanged", int'(dout), 9'h01F);
        rd_en_a_n = 1'b1;
        drain();
        chk(dout === 9'h0C3, "R5 word after gating", int'(dout), 9'h0C3);

        // R12: concurrent streaming with unrelated clocks.
        base_pop = popped;
        @(negedge rd_clk); rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            bit a;
            a = 1'b0;
            while (!a) push_word(9'h100 + 9'(i), a);
        end
        @(negedge wr_clk); wr_en_n = 1'b1;
        while (exp_q.size() != 0) @(negedge rd_clk);
        settle();
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        chk(popped - base_pop == 40, "R12 stream count", popped - base_pop, 40);
        chk(empty === 1'b1, "R12 empty at end", empty, 1);

        // R11: load mode; offsets 2, 3, then 3 again into almost-empty.
        do_reset(1'b0);
        load_word(9'h002);
        load_word(9'h003);
        load_word(9'h003);
        @(negedge wr_clk); wr_en_n = 1'b1; wr_en_ld = 1'b1;
        settle();
        chk(empty === 1'b1, "R11 loads not stored", empty, 1);
        push_n(3, 9'h040);
        settle();
        chk(almost_empty === 1'b1, "R11 ae offset 3 at 3 words", almost_empty, 1);
        push_n(1, 9'h043);
        settle();
        chk(almost_empty === 1'b0, "R11 ae offset 3 at 4 words", almost_empty, 0);
        push_n(8, 9'h044);
        settle();
        chk(almost_full === 1'b0, "R11 af offset 3 at 12 words", almost_full, 0);
        push_n(1, 9'h04C);
        settle();
        chk(almost_full === 1'b1, "R11 af offset 3 at 13 words", almost_full, 1);
        drain();
        chk(exp_q.size() == 0, "R11 all words read", exp_q.size(), 0);

        finish_run();
    end
endmodule